// File: doc/BRIEF.md
# Dual-Group Invertible GPIO Bank

This block holds two groups of general-purpose pins (eight per group by default). Each group has a direction register, a data register and a polarity-inversion register. Software reaches them through indexed configuration writes and reads. Both direction and data registers are also reachable through a four-byte I/O window, whose base address software programs through two configuration indices. The block drives a pad output-enable and a pad output value for every pin. It samples every pad input through a two-flop synchronizer.

The inversion register acts in both directions. It flips the value driven onto an output pin, and it flips the synchronized level that an input pin reports. Pin 0 of the first group is push-pull. Every other pin is open-drain: it pulls low, and it releases the pad to show a high. Pin 0 of the first group also serves as a reset strap. Its pad level is captured when the active-low reset is released and is held on `strap` until the next release. A global enable bit turns on both groups. When that bit is clear, a separate enable bit for each group applies.

Top module: `gpio_pair_bank`

## Requirements
- R1: After reset, both direction registers read FFh, and both inversion registers, the enable register and both base bytes read 00h. No pad output-enable is asserted.
- R2: Configuration index F0h/F1h/F2h selects the direction, data and inversion register of group 1, and F3h/F4h/F5h selects the same three for group 2. Index 30h is the enable register (bits 2:0), 60h is the high base byte and 61h is the low base byte. Any other index reads 00h and ignores writes.
- R3: A pin drives when its group is enabled and its direction bit is 0. Its driven value is data bit XOR inversion bit. Pin 0 of group 1 is push-pull: its output-enable is 1 and its output equals the driven value.
- R4: Every other driving pin is open-drain. Its output value is always 0, and its output-enable is 1 only when the driven value is 0.
- R5: When a pin's direction bit is 1, its data-register bit reads as the pad input XOR the inversion bit. A pad change becomes visible on the read port after the second rising clock edge, and not after the first.
- R6: When a pin's direction bit is 0, its data-register bit reads back the stored data bit, not the inverted value.
- R7: Enable bit 0 turns on both groups. With bit 0 clear, bit 1 turns on group 1 and bit 2 turns on group 2. A disabled group asserts no output-enable, and its data register reads 00h.
- R8: The I/O window is open when the 16-bit base lies in 0100h–0FFFh. It matches addresses whose bits 15:2 equal those of the base. Offset 0 is the group 1 direction register, offset 1 is group 1 data, offset 2 is group 2 direction and offset 3 is group 2 data.
- R9: I/O accesses outside the window, or made while the base lies outside 0100h–0FFFh, change no register and read 00h.
- R10: `strap` takes the level of pad input 0 at the rising edge of `rst_n` and keeps it until the next rising edge of `rst_n`.
- R11: When a configuration write and an I/O window write target the same register in the same cycle, the configuration write's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; its rising edge latches the strap |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_idx` (combinational) |
| io_wr | input | 1 | I/O window write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for `io_addr` (combinational) |
| pad_in | input | 16 | Pad input levels; group 1 is bits 7:0 |
| pad_oe | output | 16 | Pad output-enables |
| pad_out | output | 16 | Pad output values |
| strap | output | 1 | Level of pad input 0 captured at reset release |

## Verification
The assertions assume the host never writes through the configuration port and the I/O window in the same cycle unless it wants the configuration value to win. They also assume `pad_in` is sampled only through the synchronizer, so the two-cycle input delay holds for any input pattern. The stimulus changes inputs only on falling clock edges. It holds `pad_in[0]` steady across each reset release so that the strap level is well defined. It drives every write for exactly one rising edge.

// File: rtl/gpio_pair_bank.sv
`timescale 1ns/1ps
module gpio_pair_bank #(
  parameter int GW = 8,
  parameter logic [7:0] IDX_EN  = 8'h30,
  parameter logic [7:0] IDX_BHI = 8'h60,
  parameter logic [7:0] IDX_BLO = 8'h61,
  parameter logic [7:0] IDX_G1  = 8'hF0,
  parameter logic [7:0] IDX_G2  = 8'hF3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_idx,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          io_wr,
  input  logic [15:0]   io_addr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  input  logic [2*GW-1:0] pad_in,
  output logic [2*GW-1:0] pad_oe,
  output logic [2*GW-1:0] pad_out,
  output logic          strap
);
  localparam int NP = 2 * GW;

  logic [GW-1:0] dir_r [2];
  logic [GW-1:0] dat_r [2];
  logic [GW-1:0] inv_r [2];
  logic [GW-1:0] grp_rd [2];
  logic [2:0]    en_r;
  logic [15:0]   base_r;
  logic [NP-1:0] s1, s2;
  logic [1:0]    on;
  logic          win_hit;
  logic          strap_q;

  assign on[0]   = en_r[0] | en_r[1];
  assign on[1]   = en_r[0] | en_r[2];
  assign win_hit = (base_r[15:12] == 4'h0) && (base_r[11:8] != 4'h0) &&
                   (io_addr[15:2] == base_r[15:2]);
  assign strap   = strap_q;

  always_ff @(posedge rst_n) strap_q <= pad_in[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        dir_r[g] <= '1;
        dat_r[g] <= '0;
        inv_r[g] <= '0;
      end
      en_r   <= '0;
      base_r <= '0;
      s1     <= '0;
      s2     <= '0;
    end else begin
      s1 <= pad_in;
      s2 <= s1;
      if (io_wr && win_hit) begin
        case (io_addr[1:0])
          2'd0: dir_r[0] <= io_wdata[GW-1:0];
          2'd1: dat_r[0] <= io_wdata[GW-1:0];
          2'd2: dir_r[1] <= io_wdata[GW-1:0];
          default: dat_r[1] <= io_wdata[GW-1:0];
        endcase
      end
      if (cfg_wr) begin
        if (cfg_idx == IDX_EN)  en_r <= cfg_wdata[2:0];
        if (cfg_idx == IDX_BHI) base_r[15:8] <= cfg_wdata;
        if (cfg_idx == IDX_BLO) base_r[7:0]  <= cfg_wdata;
        for (int g = 0; g < 2; g++) begin
          if (cfg_idx == ((g == 0) ? IDX_G1 : IDX_G2))         dir_r[g] <= cfg_wdata[GW-1:0];
          if (cfg_idx == ((g == 0) ? IDX_G1 : IDX_G2) + 8'd1)  dat_r[g] <= cfg_wdata[GW-1:0];
          if (cfg_idx == ((g == 0) ? IDX_G1 : IDX_G2) + 8'd2)  inv_r[g] <= cfg_wdata[GW-1:0];
        end
      end
    end
  end

  always_comb begin
    for (int g = 0; g < 2; g++)
      for (int i = 0; i < GW; i++)
        grp_rd[g][i] = on[g] & (dir_r[g][i] ? (s2[g*GW+i] ^ inv_r[g][i]) : dat_r[g][i]);
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_idx == IDX_EN)  cfg_rdata = {5'd0, en_r};
    if (cfg_idx == IDX_BHI) cfg_rdata = base_r[15:8];
    if (cfg_idx == IDX_BLO) cfg_rdata = base_r[7:0];
    for (int g = 0; g < 2; g++) begin
      if (cfg_idx == ((g == 0) ? IDX_G1 : IDX_G2))        cfg_rdata = 8'(dir_r[g]);
      if (cfg_idx == ((g == 0) ? IDX_G1 : IDX_G2) + 8'd1) cfg_rdata = 8'(grp_rd[g]);
      if (cfg_idx == ((g == 0) ? IDX_G1 : IDX_G2) + 8'd2) cfg_rdata = 8'(inv_r[g]);
    end
  end

  always_comb begin
    io_rdata = '0;
    if (win_hit)
      case (io_addr[1:0])
        2'd0: io_rdata = 8'(dir_r[0]);
        2'd1: io_rdata = 8'(grp_rd[0]);
        2'd2: io_rdata = 8'(dir_r[1]);
        default: io_rdata = 8'(grp_rd[1]);
      endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_grp
    for (genvar i = 0; i < GW; i++) begin : g_pin
      wire drv = on[g] & ~dir_r[g][i];
      wire val = dat_r[g][i] ^ inv_r[g][i];
      if (g == 0 && i == 0) begin : g_pp
        assign pad_oe[g*GW+i]  = drv;
        assign pad_out[g*GW+i] = drv & val;
      end else begin : g_od
        assign pad_oe[g*GW+i]  = drv & ~val;
        assign pad_out[g*GW+i] = 1'b0;
      end
    end
  end

  a_r2_cfg_dir_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_idx == IDX_G1) |=> dir_r[0] == $past(cfg_wdata[GW-1:0]));
  a_r5_two_flop_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> s2 == $past(pad_in, 2));
  a_r7_off_group_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !on[1] |-> pad_oe[NP-1:GW] == '0);
  a_r8_io_dat2_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && win_hit && io_addr[1:0] == 2'd3 && !cfg_wr) |=> dat_r[1] == $past(io_wdata[GW-1:0]));
  a_r10_strap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap));
  a_r11_cfg_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_idx == IDX_G1 + 8'd1 && io_wr && win_hit && io_addr[1:0] == 2'd1)
    |=> dat_r[0] == $past(cfg_wdata[GW-1:0]));
endmodule

// File: tb/sim_gpio_pair_bank.sv
`timescale 1ns/1ps
module sim_gpio_pair_bank;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfg_wr, io_wr, strap;
  logic [7:0] cfg_idx, cfg_wdata, cfg_rdata, io_wdata, io_rdata;
  logic [15:0] io_addr, pad_in, pad_oe, pad_out;
  int total = 0, bad = 0;
  bit fin = 0;

  gpio_pair_bank u0 (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .strap(strap));

  // {dir, inv, dat, pad}
  localparam logic [31:0] VEC [7] = '{
    32'hFF_00_00_A5, 32'h00_00_5A_00, 32'h00_FF_5A_00, 32'hF0_0F_33_C3,
    32'h0F_F0_CC_3C, 32'h00_00_01_FF, 32'hFE_00_00_01 };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cw(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic iw(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic cr(input logic [7:0] idx, output logic [7:0] d);
    cfg_idx = idx; #0.5; d = cfg_rdata;
  endtask

  task automatic ir(input logic [15:0] a, output logic [7:0] d);
    io_addr = a; #0.5; d = io_rdata;
  endtask

  function automatic logic [7:0] m_oe(input logic [7:0] dir, inv, dat, input bit pp0);
    for (int i = 0; i < 8; i++)
      m_oe[i] = !dir[i] && ((pp0 && i == 0) ? 1'b1 : !(dat[i] ^ inv[i]));
  endfunction

  function automatic logic [7:0] m_out(input logic [7:0] dir, inv, dat, input bit pp0);
    m_out = 8'h00;
    if (pp0) m_out[0] = !dir[0] && (dat[0] ^ inv[0]);
  endfunction

  function automatic logic [7:0] m_rd(input logic [7:0] dir, inv, dat, pad);
    for (int i = 0; i < 8; i++) m_rd[i] = dir[i] ? (pad[i] ^ inv[i]) : dat[i];
  endfunction

  task automatic do_reset(input bit lvl);
    @(negedge clk); rst_n = 0; pad_in = {15'd0, lvl};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1; cfg_wr = 0; io_wr = 0; cfg_idx = 0; cfg_wdata = 0;
    io_addr = 0; io_wdata = 0; pad_in = 0;
    do_reset(1'b1);

    // R1 reset state
    cr(8'hF0, d); chk("R1 dir1", d, 8'hFF);
    cr(8'hF3, d); chk("R1 dir2", d, 8'hFF);
    cr(8'hF2, d); chk("R1 inv1", d, 8'h00);
    cr(8'hF5, d); chk("R1 inv2", d, 8'h00);
    cr(8'h30, d); chk("R1 en", d, 8'h00);
    cr(8'h60, d); chk("R1 base hi", d, 8'h00);
    chk("R1 oe", pad_oe, 16'h0000);
    // R10 strap captured high
    chk("R10 strap high", strap, 1'b1);
    pad_in = 16'h0000; repeat (3) @(negedge clk);
    chk("R10 strap held", strap, 1'b1);

    // R2 unmapped index
    cw(8'h40, 8'h5A); cr(8'h40, d); chk("R2 unmapped", d, 8'h00);
    cr(8'hF0, d); chk("R2 unmapped no side effect", d, 8'hFF);

    // vector table: R3 R4 R5 R6 on both groups
    cw(8'h30, 8'h01);
    foreach (VEC[k]) begin
      logic [7:0] vd, vi, vt, vp;
      {vd, vi, vt, vp} = VEC[k];
      cw(8'hF0, vd); cw(8'hF2, vi); cw(8'hF1, vt);
      cw(8'hF3, vd); cw(8'hF5, vi); cw(8'hF4, vt);
      @(negedge clk); pad_in = {vp, vp};
      repeat (3) @(negedge clk);
      chk($sformatf("R3 oe1 v%0d", k), pad_oe[7:0], m_oe(vd, vi, vt, 1));
      chk($sformatf("R3 out1 v%0d", k), pad_out[7:0], m_out(vd, vi, vt, 1));
      chk($sformatf("R4 oe2 v%0d", k), pad_oe[15:8], m_oe(vd, vi, vt, 0));
      chk($sformatf("R4 out2 v%0d", k), pad_out[15:8], 8'h00);
      cr(8'hF1, d); chk($sformatf("R5 R6 rd1 v%0d", k), d, m_rd(vd, vi, vt, vp));
      cr(8'hF4, d); chk($sformatf("R5 R6 rd2 v%0d", k), d, m_rd(vd, vi, vt, vp));
    end

    // R5 synchronizer latency
    cw(8'hF0, 8'hFF); cw(8'hF2, 8'h00);
    @(negedge clk); pad_in = 16'h0000;
    repeat (3) @(negedge clk);
    pad_in = 16'h00C3;
    @(negedge clk); cr(8'hF1, d); chk("R5 one edge old", d, 8'h00);
    @(negedge clk); cr(8'hF1, d); chk("R5 two edges new", d, 8'hC3);

    // R7 enables
    cw(8'hF0, 8'h00); cw(8'hF1, 8'h00); cw(8'hF2, 8'h00);
    cw(8'hF3, 8'h00); cw(8'hF4, 8'h00); cw(8'hF5, 8'h00);
    cw(8'h30, 8'h02);
    chk("R7 g1 only oe", pad_oe, 16'h00FF);
    cw(8'hF4, 8'h77); cr(8'hF4, d); chk("R7 off group reads 0", d, 8'h00);
    cw(8'h30, 8'h04);
    chk("R7 g2 only oe", pad_oe, 16'h8800);
    cw(8'h30, 8'h00);
    chk("R7 both off", pad_oe, 16'h0000);
    cw(8'h30, 8'h01);

    // R8 I/O window, base 0126h (bits 1:0 ignored)
    cw(8'h60, 8'h01); cw(8'h61, 8'h26);
    iw(16'h0125, 8'h3C); cr(8'hF1, d); chk("R8 io dat1", d, 8'h3C);
    iw(16'h0126, 8'h0F); cr(8'hF3, d); chk("R8 io dir2", d, 8'h0F);
    iw(16'h0127, 8'h90); cr(8'hF4, d); chk("R8 io dat2", d, 8'h90);
    ir(16'h0124, d); chk("R8 io rd dir1", d, 8'h00);
    ir(16'h0125, d); chk("R8 io rd dat1", d, 8'h3C);

    // R9 outside window / base out of range
    iw(16'h0129, 8'hAA); cr(8'hF1, d); chk("R9 miss no write", d, 8'h3C);
    ir(16'h0129, d); chk("R9 miss reads 0", d, 8'h00);
    cw(8'h60, 8'h00); cw(8'h61, 8'h24);
    iw(16'h0025, 8'h55); cr(8'hF1, d); chk("R9 low base no write", d, 8'h3C);
    ir(16'h0025, d); chk("R9 low base reads 0", d, 8'h00);

    // R11 same-cycle conflict
    cw(8'h60, 8'h01);
    @(negedge clk);
    cfg_wr = 1; cfg_idx = 8'hF1; cfg_wdata = 8'h11;
    io_wr = 1; io_addr = 16'h0125; io_wdata = 8'h22;
    @(negedge clk); cfg_wr = 0; io_wr = 0;
    cr(8'hF1, d); chk("R11 cfg wins", d, 8'h11);

    // R10 strap low on second release
    do_reset(1'b0);
    chk("R10 strap low", strap, 1'b0);
    pad_in = 16'h0001; repeat (3) @(negedge clk);
    chk("R10 strap unaffected", strap, 1'b0);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule